// File: doc/BRIEF.md
# Overlay Window and Color-Key Pixel Selector

This block sits on the host graphics pixel clock and decides, one pixel at a time, whether the display shows the incoming 8-bit graphics pixel or the pixel fetched from the video frame buffer. Two qualifiers feed the decision. The first is a rectangular window, placed by column and row counters that restart at the trailing edges of the graphics syncs. The second is a color-key match on the graphics data, in which a mask picks the bits that take part in the compare.

The two qualifiers split the screen into four areas: neither qualifier, window only, key only, and both. Each area has its own select bit. A qualifier that is switched off never counts as true, so an area that needs it cannot occur. The select decision is forced to graphics whenever either sync is active. It then passes through a programmable skew line, so the mux control lines up with a downstream data path whose delay is between two and five clocks. The active level of each sync input can be programmed.

Top module: `ovl_keysel`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `vid_sel` is 0 (graphics), whatever the inputs and select bits are.
- R2: The column counter is 0 for the first pixel whose sync is inactive after an active horizontal sync. It then rises by one each clock and saturates at its maximum.
- R3: Row 0 is the line that starts with the first horizontal sync pulse to begin after the vertical sync has ended. Each later horizontal sync pulse that begins outside vertical sync adds one row.
- R4: The window holds columns x with `win_x_start` <= x < `win_x_end` and rows y with `win_y_start` <= y < `win_y_end`. It counts as true only when `win_en` is 1.
- R5: A key match occurs when `((gfx_data ^ key_ref) & ~key_mask) == 0`. A mask bit of 1 makes that data bit a don't-care.
- R6: The key qualifier counts as true only when `key_en` is 1 and the data match.
- R7: For a pixel outside sync, `vid_sel` equals `area_sel[{key, win}]`. Bit 0 is neither, bit 1 window only, bit 2 key only, bit 3 both. 1 selects frame-buffer video and 0 selects graphics.
- R8: With a qualifier disabled, the select bits of the areas that need it have no effect on `vid_sel`.
- R9: A pixel sampled while either sync is at its active level gives `vid_sel` = 0.
- R10: The decision for a pixel sampled on clock edge N appears on `vid_sel` right after edge N+1+`skew_code`. That is a lag of 2, 3, 4 or 5 clocks for codes 0 to 3.
- R11: A sync is active when its pin equals its polarity input (`hs_act_high`, `vs_act_high`). A polarity of 1 means active high and 0 means active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Graphics pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| gfx_data | input | 8 | Graphics pixel data |
| gfx_hsync | input | 1 | Graphics horizontal sync pin |
| gfx_vsync | input | 1 | Graphics vertical sync pin |
| hs_act_high | input | 1 | Horizontal sync active level |
| vs_act_high | input | 1 | Vertical sync active level |
| win_en | input | 1 | Window qualifier enable |
| key_en | input | 1 | Color-key qualifier enable |
| win_x_start | input | 11 | First window column |
| win_x_end | input | 11 | Column just past the window |
| win_y_start | input | 10 | First window row |
| win_y_end | input | 10 | Row just past the window |
| key_ref | input | 8 | Key compare value |
| key_mask | input | 8 | Key don't-care mask (1 = ignore bit) |
| area_sel | input | 4 | Per-area select bits, 1 = frame buffer |
| skew_code | input | 2 | Extra control delay, 0 to 3 clocks |
| vid_sel | output | 1 | Mux control: 1 = frame buffer, 0 = graphics |

## Verification
The bench drives whole rasters and predicts every pixel's select value, so the window edges are checked on both sides. A design with an off-by-one start or an inclusive end would show video one column or row early or late. Masked key compares are run with partial and full masks, and select patterns are chosen so that a swapped area index or an ignored enable lights the wrong pixels. Every skew code is run; a wrong tap would shift the whole pattern by a clock. Syncs are also run active low, where a design with a fixed polarity would count columns from the wrong edge and pass video during blanking.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  // Area index built as {key_hit, win_hit}
  typedef enum logic [1:0] {
    AREA_NONE = 2'b00,
    AREA_WIN  = 2'b01,
    AREA_KEY  = 2'b10,
    AREA_BOTH = 2'b11
  } area_e;
endpackage

// File: rtl/ovl_raster_cnt.sv
module ovl_raster_cnt #(
  parameter int XW = 11,
  parameter int YW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pix_in,
  input  logic          hs_pin,
  input  logic          vs_pin,
  input  logic          hs_pol,
  input  logic          vs_pol,
  output logic [DW-1:0] pix_q,
  output logic          sync_q,
  output logic [XW-1:0] x_pos,
  output logic [YW-1:0] y_pos
);
  localparam logic [XW-1:0] XMAX = '1;

  logic hs_act, vs_act;
  logic hs_q, vs_q, hs_d;

  assign hs_act = (hs_pin == hs_pol);
  assign vs_act = (vs_pin == vs_pol);

  // Input stage; reset state looks like sync so nothing is selected
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q <= '0;
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
      hs_d  <= 1'b1;
    end else begin
      pix_q <= pix_in;
      hs_q  <= hs_act;
      vs_q  <= vs_act;
      hs_d  <= hs_q;
    end
  end

  // Column counter, aligned with the registered pixel
  always_ff @(posedge clk) begin
    if (rst || hs_q)
      x_pos <= '0;
    else if (x_pos != XMAX)
      x_pos <= x_pos + 1'b1;
  end

  // Row counter: parked at all-ones in vsync, steps at each hsync start
  always_ff @(posedge clk) begin
    if (rst || vs_q)
      y_pos <= '1;
    else if (hs_q && !hs_d)
      y_pos <= y_pos + 1'b1;
  end

  assign sync_q = hs_q | vs_q;
endmodule

// File: rtl/ovl_qualify.sv
module ovl_qualify
  import ovl_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 10,
  parameter int DW = 8
) (
  input  logic [DW-1:0] pix,
  input  logic          sync,
  input  logic [XW-1:0] x_pos,
  input  logic [YW-1:0] y_pos,
  input  logic          win_en,
  input  logic          key_en,
  input  logic [XW-1:0] x_lo,
  input  logic [XW-1:0] x_hi,
  input  logic [YW-1:0] y_lo,
  input  logic [YW-1:0] y_hi,
  input  logic [DW-1:0] key_ref,
  input  logic [DW-1:0] key_mask,
  input  logic [3:0]    area_sel,
  output logic          fb_sel
);
  logic  in_x, in_y, win_hit, key_hit;
  area_e area;

  always_comb begin
    in_x    = (x_pos >= x_lo) && (x_pos < x_hi);
    in_y    = (y_pos >= y_lo) && (y_pos < y_hi);
    win_hit = win_en && in_x && in_y;
    key_hit = key_en && (((pix ^ key_ref) & ~key_mask) == '0);
    area    = area_e'({key_hit, win_hit});
    fb_sel  = !sync && area_sel[area];
  end
endmodule

// File: rtl/ovl_skew_line.sv
module ovl_skew_line #(
  parameter int EXTRA = 3,
  localparam int CW = (EXTRA > 0) ? $clog2(EXTRA + 1) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          d_in,
  input  logic [CW-1:0] code,
  output logic          d_out
);
  logic [EXTRA:0] tap;

  assign tap[0] = d_in;

  for (genvar i = 1; i <= EXTRA; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) tap[i] <= 1'b0;
      else     tap[i] <= tap[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) d_out <= 1'b0;
    else     d_out <= tap[code];
  end
endmodule

// File: rtl/ovl_keysel.sv
module ovl_keysel #(
  parameter int XW = 11,
  parameter int YW = 10,
  parameter int DW = 8,
  parameter int SKEW_EXTRA = 3,
  localparam int SCW = (SKEW_EXTRA > 0) ? $clog2(SKEW_EXTRA + 1) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  gfx_data,
  input  logic           gfx_hsync,
  input  logic           gfx_vsync,
  input  logic           hs_act_high,
  input  logic           vs_act_high,
  input  logic           win_en,
  input  logic           key_en,
  input  logic [XW-1:0]  win_x_start,
  input  logic [XW-1:0]  win_x_end,
  input  logic [YW-1:0]  win_y_start,
  input  logic [YW-1:0]  win_y_end,
  input  logic [DW-1:0]  key_ref,
  input  logic [DW-1:0]  key_mask,
  input  logic [3:0]     area_sel,
  input  logic [SCW-1:0] skew_code,
  output logic           vid_sel
);
  logic [DW-1:0] pix_q;
  logic          sync_q;
  logic [XW-1:0] x_pos;
  logic [YW-1:0] y_pos;
  logic          fb_sel;

  ovl_raster_cnt #(.XW(XW), .YW(YW), .DW(DW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .pix_in (gfx_data),
    .hs_pin (gfx_hsync),
    .vs_pin (gfx_vsync),
    .hs_pol (hs_act_high),
    .vs_pol (vs_act_high),
    .pix_q  (pix_q),
    .sync_q (sync_q),
    .x_pos  (x_pos),
    .y_pos  (y_pos)
  );

  ovl_qualify #(.XW(XW), .YW(YW), .DW(DW)) u_qual (
    .pix      (pix_q),
    .sync     (sync_q),
    .x_pos    (x_pos),
    .y_pos    (y_pos),
    .win_en   (win_en),
    .key_en   (key_en),
    .x_lo     (win_x_start),
    .x_hi     (win_x_end),
    .y_lo     (win_y_start),
    .y_hi     (win_y_end),
    .key_ref  (key_ref),
    .key_mask (key_mask),
    .area_sel (area_sel),
    .fb_sel   (fb_sel)
  );

  ovl_skew_line #(.EXTRA(SKEW_EXTRA)) u_skew (
    .clk   (clk),
    .rst   (rst),
    .d_in  (fb_sel),
    .code  (skew_code),
    .d_out (vid_sel)
  );
endmodule

// File: rtl/ovl_sel_chk.sv
module ovl_sel_chk (
  input logic       clk,
  input logic       rst,
  input logic       gfx_hsync,
  input logic       gfx_vsync,
  input logic       hs_act_high,
  input logic       vs_act_high,
  input logic [3:0] area_sel,
  input logic [1:0] skew_code,
  input logic       vid_sel
);
  logic sync_in;
  assign sync_in = (gfx_hsync == hs_act_high) || (gfx_vsync == vs_act_high);

  // R1: first cycle out of reset shows graphics
  p_reset_gfx_r1: assert property (@(posedge clk) $past(rst) |-> !vid_sel);

  // R9: a sync pixel never selects video (shortest skew)
  p_sync_gfx_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(skew_code) == 2'd0 && $past(sync_in, 2)) |-> !vid_sel);

  // R10: with one extra stage, the sync pixel lands one clock later
  p_skew1_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(skew_code) == 2'd1 && $past(sync_in, 3)) |-> !vid_sel);

  // R7: all select bits clear gives graphics
  p_sel_none_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(skew_code) == 2'd0 && $past(area_sel) == 4'h0) |-> !vid_sel);

  // R7: all select bits set gives video outside sync
  p_sel_all_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(skew_code) == 2'd0 && $past(area_sel) == 4'hF &&
     !$past(sync_in, 2) && !$past(rst) && !$past(rst, 2)) |-> vid_sel);
endmodule

bind ovl_keysel ovl_sel_chk u_chk (.*);

// File: tb/ovl_keysel_test.sv
module ovl_keysel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  gfx_data = '0;
  logic        hs_l = 1'b0, vs_l = 1'b0;
  logic        hs_act_high = 1'b1, vs_act_high = 1'b1;
  logic        gfx_hsync, gfx_vsync;
  logic        win_en = 1'b0, key_en = 1'b0;
  logic [10:0] win_x_start = '0, win_x_end = '0;
  logic [9:0]  win_y_start = '0, win_y_end = '0;
  logic [7:0]  key_ref = '0, key_mask = '0;
  logic [3:0]  area_sel = 4'hF;
  logic [1:0]  skew_code = '0;
  logic        vid_sel;

  int checks = 0, errors = 0;
  int wr = 0;
  int seed = 0;
  bit hist [16];
  string cur_req = "R1";
  localparam int W = 24;

  assign gfx_hsync = hs_l ~^ hs_act_high;
  assign gfx_vsync = vs_l ~^ vs_act_high;

  always #10 clk = ~clk;

  ovl_keysel uut (.*);

  task automatic check(input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", cur_req, what, act, exp);
    end
  endtask

  function automatic bit exp_of(input int x, input int y, input logic [7:0] d);
    bit w, k;
    w = win_en && x >= win_x_start && x < win_x_end && y >= win_y_start && y < win_y_end;
    k = key_en && (((d ^ key_ref) & ~key_mask) == 8'h00);
    return area_sel[{k, w}];
  endfunction

  // One pixel: check the output due now, then drive the next pixel
  task automatic step(input bit hs, input bit vs, input logic [7:0] d, input bit e);
    int lag;
    @(negedge clk);
    lag = 2 + int'(skew_code);
    if (wr >= lag) check(vid_sel, hist[(wr - lag) % 16], "pixel");
    hs_l = hs; vs_l = vs; gfx_data = d;
    hist[wr % 16] = e;
    wr++;
  endtask

  task automatic run_frame(input int nlines);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 8'h00, 1'b0);
    for (int y = 0; y < nlines; y++) begin
      for (int h = 0; h < 3; h++) step(1'b1, 1'b0, 8'hFF, 1'b0);
      for (int x = 0; x < W; x++) begin
        logic [7:0] d;
        d = 8'((x * 37 + y * 11 + seed) & 255);
        step(1'b0, 1'b0, d, exp_of(x, y, d));
      end
    end
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic t_reset();
    cur_req = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk); check(vid_sel, 1'b0, "in reset");
    rst = 1'b0;
    @(negedge clk); check(vid_sel, 1'b0, "first cycle after reset");
    hs_l = 1'b1;
    repeat (8) step(1'b1, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic t_neither();
    cur_req = "R7 R9 R2";
    win_en = 0; key_en = 0; area_sel = 4'b0001;
    run_frame(2);
    area_sel = 4'b0000;
    run_frame(1);
  endtask

  task automatic t_window();
    cur_req = "R4 R2 R3";
    win_en = 1; key_en = 0; area_sel = 4'b0010;
    win_x_start = 3; win_x_end = 9; win_y_start = 1; win_y_end = 3;
    run_frame(4);
    win_x_start = 0; win_x_end = 1; win_y_start = 0; win_y_end = 1;
    run_frame(2);
    win_x_start = 20; win_x_end = 24; win_y_start = 3; win_y_end = 4;
    run_frame(4);
  endtask

  task automatic t_key();
    cur_req = "R5 R6";
    win_en = 0; key_en = 1; area_sel = 4'b0100;
    key_ref = 8'h25; key_mask = 8'hE0; seed = 0;
    run_frame(3);
    key_ref = 8'h5A; key_mask = 8'h0F; seed = 7;
    run_frame(3);
    key_mask = 8'hFF;
    run_frame(1);
    key_en = 0;
    run_frame(1);
  endtask

  task automatic t_both();
    cur_req = "R7";
    win_en = 1; key_en = 1;
    win_x_start = 4; win_x_end = 16; win_y_start = 0; win_y_end = 2;
    key_ref = 8'h00; key_mask = 8'hF0; seed = 3;
    area_sel = 4'b1000; run_frame(3);
    area_sel = 4'b0110; run_frame(3);
    area_sel = 4'b1001; run_frame(3);
  endtask

  task automatic t_disabled();
    cur_req = "R8";
    win_x_start = 2; win_x_end = 20; win_y_start = 0; win_y_end = 3;
    key_ref = 8'h00; key_mask = 8'hF0; seed = 5;
    win_en = 0; key_en = 1; area_sel = 4'b1011;
    run_frame(3);
    win_en = 1; key_en = 0; area_sel = 4'b1101;
    run_frame(3);
  endtask

  task automatic t_skew();
    cur_req = "R10";
    win_en = 1; key_en = 0; area_sel = 4'b0010;
    win_x_start = 5; win_x_end = 7; win_y_start = 0; win_y_end = 2;
    for (int c = 0; c < 4; c++) begin
      skew_code = 2'(c);
      run_frame(2);
    end
    skew_code = 2'd0;
  endtask

  task automatic t_pol();
    cur_req = "R11";
    hs_act_high = 0; vs_act_high = 0;
    win_en = 1; key_en = 0; area_sel = 4'b0011;
    win_x_start = 0; win_x_end = 2; win_y_start = 1; win_y_end = 2;
    run_frame(3);
    hs_act_high = 1; vs_act_high = 0;
    run_frame(2);
  endtask

  initial begin
    t_reset();
    t_neither();
    t_window();
    t_key();
    t_both();
    t_disabled();
    t_skew();
    t_pol();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog %s: got timeout expected completion", cur_req);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule